// File: doc/BRIEF.md
# Watchdog Timer with Programmable Expiry Action

This block is a down-counting supervision timer that runs on the system clock. Software first writes a start value into the load register. It then selects what expiry should do and sets the enable bit. From then on, software must write the load register again at regular intervals. Each such write restarts the countdown. If the count reaches zero before a restart, the timer takes the action selected in the control register.

Three actions are available: a one-cycle hardware reset request, a non-maskable interrupt, or an ordinary interrupt. A reset request also returns the timer itself to its idle state, in the same way the chip-wide reset would. A reset-cause flag is the exception: it is cleared only by power-on reset or by an explicit write-one-to-clear. Software can therefore read the flag after the chip comes back up. In either interrupt mode the count stays at zero and the interrupt line stays high until software acknowledges it.

Top module: `wdog_top`

## Requirements
- R1: After power-on reset (`por_n` low at a clock edge), all three event outputs are low. The control word, the load register and the current count all read zero.
- R2: The counter is loaded from the load register in two cases: a control write sets the enable bit (control bit 0) while the timer is disabled, or a write to the load address arrives while the timer is enabled. Once loaded, the counter decrements by one per clock. A control write that sets enable while the timer is already enabled does not reload the counter.
- R3: Register addresses: 0 is load, 1 is control, 2 is the read-only current count. A write to address 0 while enabled restarts the countdown from the written value, and regular writes of this kind prevent expiry. A write to address 0 while disabled only stores the value and leaves the count unchanged.
- R4: Expiry happens when an enabled counter sits at zero. The selected event output rises N+1 clocks after the clock edge that captured the enabling write, where N is the loaded value. A load value of 0 raises the event one clock after enabling.
- R5: The action field is control bits 2:1. With code 00 (reset), expiry drives `wd_rst_req` high for exactly one clock. The same edge clears enable, the action field, the load register and the count, and the timer then stays idle.
- R6: Code 01 raises `wd_nmi`. Codes 10 and 11 both raise `wd_irq`. The count holds at zero and the raised line, shown as pending in control bit 8, stays high until software writes 1 to bit 8.
- R7: An acknowledge written while the timer is still enabled with a count of zero does not lower the event line: a new expiry takes priority over the acknowledge.
- R8: A watchdog reset sets control bit 15 (reset cause). The flag survives the self-reset and is unaffected by control writes that leave bit 15 at 0. It is cleared by writing 1 to bit 15 or by power-on reset.
- R9: While disabled, the count holds its value and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 load, 1 control, 2 count) |
| bus_wdata | input | CNT_W | Register write data |
| bus_rdata | output | CNT_W | Register read data, combinational on bus_addr |
| wd_rst_req | output | 1 | One-clock hardware reset request |
| wd_nmi | output | 1 | Non-maskable interrupt, held until acknowledged |
| wd_irq | output | 1 | General interrupt, held until acknowledged |

## Verification
A write takes effect at the edge that samples it. The event output for a load of N rises at the edge N+1 clocks after the enabling write and is still low at the edge N clocks after it. A reset request is high for the single cycle after that edge. For each write, the driver records the cycle number of the edge that captured it and queues the expected level of each output for the exact cycle where it is due, including the cycle just before the edge. The monitor compares these at the falling edge of that cycle. Register reads, including the live count, which is computed as N minus the clocks elapsed, are sampled at a falling edge once the bus address has settled, so every compared value is stable when it is read.

// File: rtl/wdog_pkg.sv
// Shared register map and expiry action encoding for the watchdog timer.
package wdog_pkg;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_LOAD  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd2;

    localparam int unsigned BIT_EN     = 0;
    localparam int unsigned BIT_ACT_LO = 1;
    localparam int unsigned BIT_ACT_HI = 2;
    localparam int unsigned BIT_EVT    = 8;
    localparam int unsigned BIT_CAUSE  = 15;

    typedef enum logic [1:0] {
        ACT_RESET   = 2'b00,
        ACT_NMI     = 2'b01,
        ACT_IRQ     = 2'b10,
        ACT_IRQ_ALT = 2'b11
    } wd_action_e;
endpackage

// File: rtl/wdog_regs.sv
// Register file: holds the load value, the enable bit and the action field.
// It also decodes writes into reload and write-one-to-clear pulses.
// Assumes a single-cycle write strobe. A watchdog reset (fire) takes
// priority over any write presented in the same cycle.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic              fire,
    output logic [W-1:0]      load_q,
    output logic              en_q,
    output wd_action_e        act_q,
    output logic              reload,
    output logic [W-1:0]      reload_val,
    output logic              ack_evt,
    output logic              clr_cause
);
    logic wr_load;
    logic wr_ctrl;

    // Decode bus writes into reload and clear requests.
    always_comb begin
        wr_load    = we && (addr == ADDR_LOAD);
        wr_ctrl    = we && (addr == ADDR_CTRL);
        reload     = (wr_load && en_q) || (wr_ctrl && wdata[BIT_EN] && !en_q);
        reload_val = wr_load ? wdata : load_q;
        ack_evt    = wr_ctrl && wdata[BIT_EVT];
        clr_cause  = wr_ctrl && wdata[BIT_CAUSE];
    end

    // Configuration registers; a watchdog reset returns them to idle.
    always_ff @(posedge clk) begin
        if (!por_n || fire) begin
            load_q <= '0;
            en_q   <= 1'b0;
            act_q  <= ACT_RESET;
        end else begin
            if (wr_load) begin
                load_q <= wdata;
            end
            if (wr_ctrl) begin
                en_q  <= wdata[BIT_EN];
                act_q <= wd_action_e'(wdata[BIT_ACT_HI:BIT_ACT_LO]);
            end
        end
    end
endmodule

// File: rtl/wdog_counter.sv
// Down counter: reloads on request, decrements while enabled, and stops at
// zero. Expiry is the level condition "enabled and at zero".
// Assumes fire and reload never need to coexist: fire wins.
module wdog_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         en,
    input  logic         reload,
    input  logic [W-1:0] reload_val,
    input  logic         fire,
    output logic [W-1:0] cnt_q,
    output logic         expired
);
    // Expiry flag for the event logic.
    always_comb begin
        expired = en && (cnt_q == '0);
    end

    // Count register with reset, reload and saturating decrement.
    always_ff @(posedge clk) begin
        if (!por_n || fire) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= reload_val;
        end else if (en && (cnt_q != '0)) begin
            cnt_q <= cnt_q - W'(1);
        end
    end
endmodule

// File: rtl/wdog_events.sv
// Expiry actions: a one-cycle reset request, held NMI or IRQ lines, and the
// sticky reset-cause flag. Assumes expired is a level from the counter.
// A new expiry takes priority over an acknowledge in the same cycle.
module wdog_events
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       expired,
    input  wd_action_e act,
    input  logic       ack_evt,
    input  logic       clr_cause,
    output logic       fire,
    output logic       rst_req,
    output logic       nmi,
    output logic       irq,
    output logic       evt_q,
    output logic       cause_q
);
    logic raise;

    // Split expiry by the selected action; route the pending event.
    always_comb begin
        fire  = expired && (act == ACT_RESET);
        raise = expired && (act != ACT_RESET);
        nmi   = evt_q && (act == ACT_NMI);
        irq   = evt_q && ((act == ACT_IRQ) || (act == ACT_IRQ_ALT));
    end

    // Event, reset pulse and reset-cause state.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            rst_req <= 1'b0;
            evt_q   <= 1'b0;
            cause_q <= 1'b0;
        end else begin
            rst_req <= fire;
            evt_q   <= !fire && (raise || (evt_q && !ack_evt));
            cause_q <= fire || (cause_q && !clr_cause);
        end
    end
endmodule

// File: rtl/wdog_top.sv
// Watchdog timer top: wires the register file, counter and event logic, and
// builds the combinational read mux. Assumes CNT_W >= 16 so the control
// word fits.
module wdog_top
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [CNT_W-1:0]    bus_wdata,
    output logic [CNT_W-1:0]    bus_rdata,
    output logic                wd_rst_req,
    output logic                wd_nmi,
    output logic                wd_irq
);
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] cnt_q;
    logic             en_q;
    wd_action_e       act_q;
    logic             reload;
    logic             ack_evt;
    logic             clr_cause;
    logic             fire;
    logic             expired;
    logic             evt_q;
    logic             cause_q;

    wdog_regs #(.W(CNT_W)) u_regs (
        .clk        (clk),
        .por_n      (por_n),
        .we         (bus_we),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .fire       (fire),
        .load_q     (load_q),
        .en_q       (en_q),
        .act_q      (act_q),
        .reload     (reload),
        .reload_val (reload_val),
        .ack_evt    (ack_evt),
        .clr_cause  (clr_cause)
    );

    wdog_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .por_n      (por_n),
        .en         (en_q),
        .reload     (reload),
        .reload_val (reload_val),
        .fire       (fire),
        .cnt_q      (cnt_q),
        .expired    (expired)
    );

    wdog_events u_evt (
        .clk       (clk),
        .por_n     (por_n),
        .expired   (expired),
        .act       (act_q),
        .ack_evt   (ack_evt),
        .clr_cause (clr_cause),
        .fire      (fire),
        .rst_req   (wd_rst_req),
        .nmi       (wd_nmi),
        .irq       (wd_irq),
        .evt_q     (evt_q),
        .cause_q   (cause_q)
    );

    // Register read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_LOAD:  bus_rdata = load_q;
            ADDR_CTRL: begin
                bus_rdata[BIT_EN]                 = en_q;
                bus_rdata[BIT_ACT_HI:BIT_ACT_LO] = act_q;
                bus_rdata[BIT_EVT]                = evt_q;
                bus_rdata[BIT_CAUSE]              = cause_q;
            end
            ADDR_COUNT: bus_rdata = cnt_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_chk.sv
// Assertion checker for wdog_top, attached with bind below.
module wdog_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         por_n,
    input logic         rst_req,
    input logic         nmi,
    input logic         irq,
    input logic         en,
    input logic [W-1:0] cnt,
    input logic         reload,
    input logic         fire,
    input logic         evt,
    input logic         ack,
    input logic         cause
);
    // R2: an enabled nonzero count steps down by one
    p_count_dec_r2: assert property (@(posedge clk) disable iff (!por_n)
        (en && (cnt != '0) && !reload) |=> (cnt == $past(cnt) - W'(1)));

    // R6: an expired count holds at zero
    p_zero_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
        (en && (cnt == '0) && !reload && !fire) |=> (cnt == '0));

    // R6: a pending event stays until acknowledged
    p_evt_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
        (evt && !ack && !fire) |=> evt);

    // R5: reset request lasts one cycle
    p_rst_pulse_r5: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> !rst_req);

    // R5: the timer is idle while the reset request is high
    p_rst_idle_r5: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> (!en && (cnt == '0)));

    // R8: the cause flag is set whenever a reset request is out
    p_cause_set_r8: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> cause);

    // R9: a disabled counter without reload keeps its value
    p_frozen_r9: assert property (@(posedge clk) disable iff (!por_n)
        (!en && !reload) |=> $stable(cnt));

    // R6: at most one event output at a time
    p_one_event_r6: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({rst_req, nmi, irq}));
endmodule

bind wdog_top wdog_chk #(.W(CNT_W)) u_chk (
    .clk     (clk),
    .por_n   (por_n),
    .rst_req (wd_rst_req),
    .nmi     (wd_nmi),
    .irq     (wd_irq),
    .en      (en_q),
    .cnt     (cnt_q),
    .reload  (reload),
    .fire    (fire),
    .evt     (evt_q),
    .ack     (ack_evt),
    .cause   (cause_q)
);

// File: tb/tb_wdog_top.sv
// Scoreboard bench: the driver queues expected output levels per cycle,
// the monitor pops and compares them at falling edges.
module tb_wdog_top;
    localparam int unsigned W = 32;
    localparam int SIG_RST = 0;
    localparam int SIG_NMI = 1;
    localparam int SIG_IRQ = 2;

    typedef struct {
        int          sig;
        logic [31:0] val;
        int          due;
        string       req;
    } exp_t;

    logic         clk = 1'b0;
    logic         por_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         wd_rst_req;
    logic         wd_nmi;
    logic         wd_irq;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t q[$];

    wdog_top #(.CNT_W(W)) dut (
        .clk        (clk),
        .por_n      (por_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .wd_rst_req (wd_rst_req),
        .wd_nmi     (wd_nmi),
        .wd_irq     (wd_irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (cycle %0d)", req, got, exp, cyc);
        end
    endtask

    function automatic logic [31:0] sel(input int sig);
        case (sig)
            SIG_RST: return {31'd0, wd_rst_req};
            SIG_NMI: return {31'd0, wd_nmi};
            default: return {31'd0, wd_irq};
        endcase
    endfunction

    task automatic push(input int sig, input logic [31:0] val, input int due, input string req);
        exp_t e;
        e.sig = sig; e.val = val; e.due = due; e.req = req;
        q.push_back(e);
    endtask

    // Monitor: compare each queued expectation in its due cycle.
    always @(negedge clk) begin
        exp_t e;
        while (q.size() > 0 && q[0].due <= cyc) begin
            e = q.pop_front();
            chk(e.req, sel(e.sig), e.val);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic rd_val(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic rd_cnt_chk(input int c0, input int n, input string req);
        @(negedge clk);
        bus_addr = 2'd2;
        #1;
        chk(req, bus_rdata, 32'(n - (cyc - c0)));
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Watchdog for a hung run.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    // Driver.
    initial begin
        int c0;
        logic [31:0] v1;
        logic [31:0] v2;
        repeat (3) @(negedge clk);
        por_n = 1'b1;

        // R1: reset state
        chk("R1 rst_req", {31'd0, wd_rst_req}, 0);
        chk("R1 nmi", {31'd0, wd_nmi}, 0);
        chk("R1 irq", {31'd0, wd_irq}, 0);
        rd_chk(2'd1, 0, "R1 ctrl");
        rd_chk(2'd0, 0, "R1 load");
        rd_chk(2'd2, 0, "R1 count");

        // R3: load while disabled does not start counting
        wr(2'd0, 10);
        rd_chk(2'd2, 0, "R3 disabled load");

        // R4/R2: NMI mode expiry timing
        wr(2'd1, 32'h3);
        c0 = cyc;
        push(SIG_NMI, 0, c0 + 10, "R4 nmi before");
        push(SIG_NMI, 1, c0 + 11, "R4 nmi at N+1");
        rd_cnt_chk(c0, 10, "R2 countdown");
        wr(2'd1, 32'h3);
        rd_cnt_chk(c0, 10, "R2 enable again no reload");
        wait_until(c0 + 14);
        rd_chk(2'd2, 0, "R6 count holds zero");
        rd_chk(2'd1, 32'h103, "R6 pending bit");
        chk("R6 nmi held", {31'd0, wd_nmi}, 1);
        chk("R6 irq quiet", {31'd0, wd_irq}, 0);

        // R7: acknowledge while still expired does not lower
        wr(2'd1, 32'h103);
        chk("R7 ack loses to expiry", {31'd0, wd_nmi}, 1);

        // R3: reload, then R6 acknowledge
        wr(2'd0, 20);
        c0 = cyc;
        rd_cnt_chk(c0, 20, "R3 reload value");
        wr(2'd1, 32'h103);
        chk("R6 ack clears nmi", {31'd0, wd_nmi}, 0);

        // R3: periodic kicks prevent expiry
        for (int k = 0; k < 5; k++) begin
            wait_until(cyc + 10);
            wr(2'd0, 20);
            chk("R3 kick keeps quiet", {31'd0, wd_nmi}, 0);
        end
        c0 = cyc;
        push(SIG_NMI, 0, c0 + 20, "R3 last kick window");
        push(SIG_NMI, 1, c0 + 21, "R4 expiry after kicks");
        wait_until(c0 + 23);
        wr(2'd1, 32'h2);
        wr(2'd1, 32'h102);
        chk("R6 ack after disable", {31'd0, wd_nmi}, 0);

        // R9: disabled counter freezes
        wr(2'd0, 50);
        wr(2'd1, 32'h3);
        wait_until(cyc + 5);
        wr(2'd1, 32'h2);
        rd_val(2'd2, v1);
        wait_until(cyc + 10);
        rd_val(2'd2, v2);
        chk("R9 frozen count", v2, v1);
        chk("R9 count was moving", {31'd0, (v1 < 50 && v1 > 0)}, 1);
        wr(2'd0, 7);
        rd_chk(2'd2, v1, "R3 disabled load keeps count");
        chk("R9 no event", {29'd0, wd_rst_req, wd_nmi, wd_irq}, 0);

        // R6: general interrupt, code 10
        wr(2'd0, 5);
        wr(2'd1, 32'h5);
        c0 = cyc;
        push(SIG_IRQ, 0, c0 + 5, "R4 irq before");
        push(SIG_IRQ, 1, c0 + 6, "R4 irq at N+1");
        push(SIG_NMI, 0, c0 + 6, "R6 nmi quiet in irq mode");
        wait_until(c0 + 8);
        wr(2'd1, 32'h4);
        wr(2'd1, 32'h104);
        chk("R6 irq ack", {31'd0, wd_irq}, 0);

        // R4 load zero, R6 code 11
        wr(2'd0, 0);
        wr(2'd1, 32'h7);
        c0 = cyc;
        chk("R4 zero load not yet", {31'd0, wd_irq}, 0);
        push(SIG_IRQ, 1, c0 + 1, "R4 zero load fires next cycle");
        wait_until(c0 + 3);
        wr(2'd1, 32'h6);
        wr(2'd1, 32'h106);
        chk("R6 alt code ack", {31'd0, wd_irq}, 0);

        // R5: reset action
        wr(2'd0, 8);
        wr(2'd1, 32'h1);
        c0 = cyc;
        push(SIG_RST, 0, c0 + 8, "R5 rst before");
        push(SIG_RST, 1, c0 + 9, "R5 rst pulse");
        push(SIG_RST, 0, c0 + 10, "R5 rst one cycle");
        wait_until(c0 + 12);
        rd_chk(2'd1, 32'h8000, "R5 R8 idle with cause");
        rd_chk(2'd0, 0, "R5 load cleared");
        rd_chk(2'd2, 0, "R5 count cleared");
        wait_until(cyc + 5);
        chk("R5 stays idle", {29'd0, wd_rst_req, wd_nmi, wd_irq}, 0);

        // R8: cause flag survives writes of zero, cleared by W1C
        wr(2'd1, 32'h2);
        rd_chk(2'd1, 32'h8002, "R8 survives write");
        wr(2'd1, 32'h8000);
        rd_chk(2'd1, 0, "R8 w1c clears");

        // R8: power-on reset clears cause
        wr(2'd0, 2);
        wr(2'd1, 32'h1);
        c0 = cyc;
        wait_until(c0 + 6);
        rd_chk(2'd1, 32'h8000, "R8 cause set again");
        @(negedge clk);
        por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        rd_chk(2'd1, 0, "R8 por clears cause");

        wait (q.size() == 0);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule